// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block lets clocked on-chip logic use an external asynchronous static RAM of 32K words by 16 bits. A requester presents one access at a time over a request/acknowledge port: a word address, a read/write flag, a two-bit byte-enable and write data. The controller turns it into a timed sequence on the memory pins and answers with a single acknowledge pulse. For a read, the acknowledge comes with the captured word.

Writes are timed by the write strobe. The controller drives the data bus for a setup phase first. It then pulses the write strobe low. After the strobe rises it holds address and data for one more cycle, because the memory stores the word on that rising edge. Reads are timed by the output-enable strobe. The data bus is split into out, in and drive-enable, so an outside tristate pad can be attached. After a read, the controller waits a set turnaround time before it drives the bus again, so the memory and the controller never drive the bus at the same time. Every phase length is a parameter counted in clock cycles. Chip enable is high whenever no access is in progress, which holds the memory in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever no access is running, chip enable, write strobe, output enable and both byte selects are high (inactive), the data driver is off and the acknowledge is low.
- R2: A write changes only the byte lanes whose enable is set: `req_be[0]` covers data bits 7..0 and `req_be[1]` covers bits 15..8. Lanes that are not enabled keep their previous memory contents.
- R3: A read returns the memory word on `rsp_rdata` in the cycle of its acknowledge. Enabled lanes carry memory data and lanes that are not enabled read as zero.
- R4: Every accepted request produces exactly one acknowledge, one cycle long. A request is accepted only while the controller is idle, and a `req_valid` pulse that arrives while an access is running has no effect.
- R5: A request with both byte enables clear is acknowledged without chip enable ever going low.
- R6: During a write, the write strobe stays low for exactly WE_LOW_CYCLES cycles, with chip enable low and the data driver on. The data driver is on for SETUP_CYCLES + WE_LOW_CYCLES + 1 cycles in total, and address and data do not change across the rising edge of the strobe.
- R7: During a read, output enable stays low for exactly READ_CYCLES cycles, with the write strobe high and the data driver off.
- R8: The data driver is never on while output enable is low. It does not turn on until output enable has been high for at least TURN_CYCLES cycles.
- R9: The address does not change while chip enable stays low.
- R10: The lower byte select is low only for a cycle where `req_be[0]` was set on the accepted request, the upper byte select likewise for `req_be[1]`, and neither byte select is low while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 2 | Byte enables: bit 0 low lane, bit 1 high lane |
| req_wdata | input | 2*LANE_W | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 2*LANE_W | Read data, valid with the acknowledge of a read |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | 2*LANE_W | Data toward the pad |
| mem_dq_in | input | 2*LANE_W | Data from the pad |
| mem_dq_oe | output | 1 | Pad driver enable |

## Verification
Full-word writes and reads at the lowest, highest and a middle address show that the address and data paths are intact. Writes with a single lane set, followed by full and single-lane reads, separate which lane was written from which lane was returned. The memory model drives a marker pattern on lanes that are not selected, so a missing zero mask shows up. A request with no lanes set, a request pulse issued during a busy write, and a write issued right after a read's acknowledge test, in turn, the no-strobe path, the idle-only acceptance and the turnaround gap between output enable rising and the driver turning on.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W        = 15,
  parameter int LANE_W        = 8,
  parameter int READ_CYCLES   = 2,
  parameter int WE_LOW_CYCLES = 2,
  parameter int SETUP_CYCLES  = 1,
  parameter int TURN_CYCLES   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_be,
  input  logic [2*LANE_W-1:0] req_wdata,
  output logic                req_ack,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic                mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic                mem_ub_n,
  output logic                mem_lb_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*LANE_W-1:0] mem_dq_out,
  input  logic [2*LANE_W-1:0] mem_dq_in,
  output logic                mem_dq_oe
);

  localparam int DATA_W = 2 * LANE_W;
  localparam int MAX_A  = (READ_CYCLES > WE_LOW_CYCLES) ? READ_CYCLES : WE_LOW_CYCLES;
  localparam int MAX_PH = (MAX_A > SETUP_CYCLES) ? MAX_A : SETUP_CYCLES;
  localparam int CNT_W  = $clog2(MAX_PH + 1);
  localparam int TRN_W  = $clog2(TURN_CYCLES + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_SETUP, ST_STROBE, ST_HOLD, ST_READ, ST_ACK
  } state_t;

  state_t             state;
  logic [CNT_W-1:0]   ph_cnt;
  logic [TRN_W-1:0]   trn_cnt;
  logic [ADDR_W-1:0]  addr_q;
  logic [1:0]         be_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  lane_mask;
  logic               rd_done;

  assign lane_mask = {{LANE_W{be_q[1]}}, {LANE_W{be_q[0]}}};
  assign rd_done   = (state == ST_READ) && (ph_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ph_cnt    <= '0;
      addr_q    <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      rsp_rdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          be_q    <= req_be;
          wdata_q <= req_wdata;
          if (req_be == 2'b00) begin
            state <= ST_ACK;
          end else if (!req_write) begin
            state  <= ST_READ;
            ph_cnt <= CNT_W'(READ_CYCLES - 1);
          end else if (trn_cnt > TRN_W'(1)) begin
            state <= ST_TURN;
          end else begin
            state  <= ST_SETUP;
            ph_cnt <= CNT_W'(SETUP_CYCLES - 1);
          end
        end
        ST_TURN: if (trn_cnt <= TRN_W'(1)) begin
          state  <= ST_SETUP;
          ph_cnt <= CNT_W'(SETUP_CYCLES - 1);
        end
        ST_SETUP: if (ph_cnt == '0) begin
          state  <= ST_STROBE;
          ph_cnt <= CNT_W'(WE_LOW_CYCLES - 1);
        end else begin
          ph_cnt <= ph_cnt - 1'b1;
        end
        ST_STROBE: if (ph_cnt == '0) state <= ST_HOLD;
                   else ph_cnt <= ph_cnt - 1'b1;
        ST_HOLD:   state <= ST_ACK;
        ST_READ: if (rd_done) begin
          rsp_rdata <= mem_dq_in & lane_mask;
          state     <= ST_ACK;
        end else begin
          ph_cnt <= ph_cnt - 1'b1;
        end
        ST_ACK:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               trn_cnt <= '0;
    else if (rd_done)         trn_cnt <= TRN_W'(TURN_CYCLES);
    else if (trn_cnt != '0)   trn_cnt <= trn_cnt - 1'b1;
  end

  assign mem_ce_n   = !(state inside {ST_SETUP, ST_STROBE, ST_HOLD, ST_READ});
  assign mem_we_n   = (state != ST_STROBE);
  assign mem_oe_n   = (state != ST_READ);
  assign mem_lb_n   = mem_ce_n | !be_q[0];
  assign mem_ub_n   = mem_ce_n | !be_q[1];
  assign mem_dq_oe  = state inside {ST_SETUP, ST_STROBE, ST_HOLD};
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign req_ack    = (state == ST_ACK);

  logic [CNT_W:0] we_run, oe_run;
  logic [TRN_W:0] oe_gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
      oe_gap <= (TRN_W+1)'(TURN_CYCLES);
    end else begin
      we_run <= mem_we_n ? '0 : we_run + 1'b1;
      oe_run <= mem_oe_n ? '0 : oe_run + 1'b1;
      if (!mem_oe_n)                              oe_gap <= '0;
      else if (oe_gap < (TRN_W+1)'(TURN_CYCLES))  oe_gap <= oe_gap + 1'b1;
    end
  end

  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) req_ack |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
  AST_ACK_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> !req_ack); // R4
  AST_WE_DRIVEN:    assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (mem_dq_oe && !mem_ce_n)); // R6
  AST_WE_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && !mem_ce_n && mem_dq_oe)); // R6
  AST_WE_WIDTH:     assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (we_run == (CNT_W+1)'(WE_LOW_CYCLES))); // R6
  AST_READ_SHAPE:   assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R7
  AST_READ_WIDTH:   assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_oe_n) |-> (oe_run == (CNT_W+1)'(READ_CYCLES))); // R7
  AST_NO_FIGHT:     assert property (@(posedge clk) disable iff (!rst_n) !(mem_dq_oe && !mem_oe_n)); // R8
  AST_TURN_GAP:     assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_dq_oe) |-> (oe_gap >= (TRN_W+1)'(TURN_CYCLES))); // R8
  AST_ADDR_STEADY:  assert property (@(posedge clk) disable iff (!rst_n) (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R9
  AST_SEL_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_ub_n || !mem_lb_n) |-> !mem_ce_n); // R10

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;
  localparam int RD_C = 2, WE_C = 2, SU_C = 1, TR_C = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [15:0] dq_in_r = 16'h5A5A;

  always #10 clk = ~clk;

  sram_async_ctrl #(.ADDR_W(15), .LANE_W(8), .READ_CYCLES(RD_C), .WE_LOW_CYCLES(WE_C),
                    .SETUP_CYCLES(SU_C), .TURN_CYCLES(TR_C)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_in(dq_in_r), .mem_dq_oe(mem_dq_oe));

  int checks = 0, fails = 0, cyc = 0, ce_low_cnt = 0;
  bit busy = 1'b0;
  logic [16:0] sb_q[$];
  logic [15:0] shadow [int];
  logic [15:0] sram [int];

  function automatic logic [15:0] rd_word(input logic [15:0] m [int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // memory model: stores on rising write strobe, drives marker on unselected lanes
  always @(posedge mem_we_n) begin
    if (mem_ce_n === 1'b0) begin
      logic [15:0] w;
      w = rd_word(sram, int'(mem_addr));
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      sram[int'(mem_addr)] = w;
      check(mem_dq_oe === 1'b1, "R6 driver on at strobe edge", 32'(mem_dq_oe), 1);
    end
  end

  always @(mem_ce_n or mem_oe_n or mem_we_n or mem_addr or mem_ub_n or mem_lb_n) begin
    if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1) begin
      logic [15:0] r;
      r = rd_word(sram, int'(mem_addr));
      dq_in_r = {mem_ub_n ? 8'hC3 : r[15:8], mem_lb_n ? 8'hC3 : r[7:0]};
    end else begin
      dq_in_r = 16'h5A5A;
    end
  end

  // monitor / scoreboard
  int we_run = 0, oe_run = 0, drv_run = 0, gap = 100;
  logic drv_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) ce_low_cnt++;
      if (req_ack) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R4 unexpected ack", 1, 0);
        end else begin
          logic [16:0] it;
          it = sb_q.pop_front();
          check(1'b1, "R4 ack", 1, 1);
          if (it[16]) check(rsp_rdata === it[15:0], "R3 read data", 32'(rsp_rdata), 32'(it[15:0]));
          if (sb_q.size() == 0) busy = 1'b0;
        end
      end
      if (!mem_oe_n && mem_dq_oe) check(1'b0, "R8 bus fight", 1, 0);
      if (!mem_we_n) we_run++;
      else if (we_run > 0) begin
        check(we_run == WE_C, "R6 strobe width", 32'(we_run), 32'(WE_C));
        we_run = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (oe_run > 0) begin
        check(oe_run == RD_C, "R7 read window", 32'(oe_run), 32'(RD_C));
        oe_run = 0;
      end
      if (mem_dq_oe) drv_run++;
      else if (drv_run > 0) begin
        check(drv_run == SU_C + WE_C + 1, "R6 drive length", 32'(drv_run), 32'(SU_C + WE_C + 1));
        drv_run = 0;
      end
      if (mem_dq_oe && !drv_prev)
        check(gap >= TR_C, "R8 turnaround", 32'(gap), 32'(TR_C));
      if (!mem_oe_n) gap = 0;
      else if (!mem_dq_oe && gap < 100) gap++;
      if ((!mem_lb_n || !mem_ub_n) && mem_ce_n) check(1'b0, "R10 select without ce", 1, 0);
      drv_prev = mem_dq_oe;
    end
  end

  // driver
  task automatic do_op(input bit wr, input logic [14:0] a, input logic [1:0] be,
                       input logic [15:0] d, input bit spur);
    logic [15:0] s;
    wait (!busy);
    @(negedge clk);
    s = rd_word(shadow, int'(a));
    if (wr) begin
      if (be[0]) s[7:0]  = d[7:0];
      if (be[1]) s[15:8] = d[15:8];
      shadow[int'(a)] = s;
      sb_q.push_back({1'b0, 16'h0});
    end else begin
      sb_q.push_back({1'b1, be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00});
    end
    busy = 1'b1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    if (spur) begin
      req_write = 1'b1; req_addr = 15'h0ABC; req_be = 2'b11; req_wdata = 16'hDEAD;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      check(1'b0, "watchdog expired", 32'(cyc), 0);
      report();
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n, "R1 strobes idle",
          32'({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}), 32'h1F);
    check(!mem_dq_oe && !req_ack, "R1 driver off, no ack", 32'({mem_dq_oe, req_ack}), 0);

    do_op(1, 15'h1234, 2'b11, 16'hA1B2, 0);
    do_op(0, 15'h1234, 2'b11, 16'h0, 0);
    do_op(1, 15'h1234, 2'b01, 16'hFFEE, 0);        // R2 low lane only
    do_op(0, 15'h1234, 2'b11, 16'h0, 0);
    do_op(1, 15'h1234, 2'b10, 16'h7799, 0);        // R2 high lane only
    do_op(0, 15'h1234, 2'b11, 16'h0, 0);
    do_op(0, 15'h1234, 2'b01, 16'h0, 0);           // R3 upper masked
    do_op(0, 15'h1234, 2'b10, 16'h0, 0);           // R3 lower masked

    wait (!busy);
    n0 = ce_low_cnt;
    do_op(1, 15'h1234, 2'b00, 16'h0000, 0);        // R5 no-op
    wait (!busy);
    check(ce_low_cnt == n0, "R5 no chip enable on no-op", 32'(ce_low_cnt), 32'(n0));
    do_op(0, 15'h1234, 2'b11, 16'h0, 0);

    do_op(1, 15'h0000, 2'b11, 16'h0F0F, 0);
    do_op(1, 15'h7FFF, 2'b11, 16'hF00D, 0);
    do_op(0, 15'h0000, 2'b11, 16'h0, 0);
    do_op(0, 15'h7FFF, 2'b11, 16'h0, 0);           // R9 address edges

    do_op(1, 15'h4321, 2'b11, 16'h1111, 1);        // R4 pulse during busy ignored
    do_op(0, 15'h0ABC, 2'b11, 16'h0, 0);
    do_op(0, 15'h4321, 2'b11, 16'h0, 0);
    do_op(1, 15'h4321, 2'b01, 16'h2222, 0);        // R8 write right after read
    do_op(0, 15'h4321, 2'b11, 16'h0, 0);

    wait (!busy);
    repeat (5) @(negedge clk);
    check(sb_q.size() == 0, "R4 all requests acknowledged", 32'(sb_q.size()), 0);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle after traffic",
          32'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}), 32'hE);
    report();
    $finish;
  end
endmodule